// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single read or write transfers on a shared bus where the low 16 address bits and the 16 data bits travel on the same lines, and the top 4 address bits share their lines with status bits. A requester presents a 20-bit physical address and a segment code. It also gives a memory or I/O select, the direction, the access size (byte or word), the write data and the interrupt-enable state. The block then walks the bus through a fixed sequence of clock states and reports completion with the assembled read data.

Every bus cycle opens with an address state. In that state a one-clock latch-enable pulse tells an external latch to capture the address. A status state follows, with the strobe asserted. Next come one or more data states, stretched by wait states while the ready input is low. A release state ends the cycle, with the strobe deasserted. Byte lanes are chosen by the active-low high-byte enable together with address bit 0. A word at an odd address is carried as two byte cycles, odd byte first.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is running: `busy`=0, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0.
- R2: A request is accepted on a clock edge where `req_valid`=1 and `busy`=0. The first state after acceptance is the address state. In that state `bus_ale`=1 for exactly one clock, `bus_ad_oe`=1, `bus_ad_out` carries address bits 15:0 and `bus_ahs` carries address bits 19:16.
- R3: After the address state, `bus_ahs` carries status until the cycle ends. Bit 3 is always 0, bit 2 is the request's interrupt-enable value, and bits 1:0 are the segment code: 00 extra, 01 stack, 10 code, 11 data.
- R4: The strobe (`bus_rd_n` for reads, `bus_wr_n` for writes) goes low in the second state and stays low through the data states. It is high again in the fourth (release) state. The two strobes are never low together.
- R5: `bus_ready` is sampled on the edge that ends the third state and on the edge that ends each wait state. While it is low, another data state with the strobe held low is inserted.
- R6: For the whole cycle, `bus_mio` equals the memory select (1 memory, 0 I/O) and `bus_dtr` is 1 for a write and 0 for a read.
- R7: Lane selection shows in the address state. A word at an even address gives `bus_bhe_n`=0 with A0=0. A byte at an even address gives `bus_bhe_n`=1 with A0=0. A byte at an odd address gives `bus_bhe_n`=0 with A0=1.
- R8: A write drives its data from the second state through the release state. A word uses all 16 bits. A byte drives its value on both byte lanes. A read releases the lines (`bus_ad_oe`=0) after the address state.
- R9: Read data is taken from `bus_ad_in` on the edge that ends the last data state. An even byte comes from bits 7:0 and an odd byte from bits 15:8. It is returned in `rd_data[7:0]` with the upper byte 0. A word returns all 16 bits.
- R10: A word at odd address A runs as two back-to-back byte cycles. The first is at A (`bus_bhe_n`=0), carrying the low data byte. The second is at A+1 (modulo 2^20, `bus_bhe_n`=1), carrying the high data byte. A read assembles these bytes into `rd_data`.
- R11: `done` pulses for one clock in the release state of the final cycle, with `rd_data` valid. This comes 4+W clocks after acceptance for one cycle, or 8+2W for a split word, where W is the number of wait states per cycle. A request held high during a transfer starts no second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 20 | Physical byte address |
| req_seg | input | 2 | Segment code for status |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_ie | input | 1 | Interrupt-enable state for status |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, read data valid |
| rd_data | output | 16 | Assembled read data |
| bus_ad_out | output | 16 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_in | input | 16 | Shared lines, received value |
| bus_ahs | output | 4 | Upper address / status lines |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_mio | output | 1 | Memory / I/O indicator |
| bus_dtr | output | 1 | Transmit (1) / receive (0) direction |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Ready; low inserts wait states |

## Verification
The bench goes after odd addresses from several sides. It checks both byte-lane encodings, and a split word at the top of the address space, where the second address must wrap to zero. A design that swapped the lane encoding, took the odd byte from the wrong half, or issued the split halves in the wrong order or without the wrap would return wrong bytes or wrong addresses. Wait counts of 0 to 3 show whether ready is sampled at the right state and whether read data is taken on the final data edge and not the first. A held request shows whether the block re-accepts while busy, which would appear as an address-latch pulse with no expected cycle.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
   // Segment code placed on the two low status lines
   typedef enum logic [1:0] {
      SEG_EXTRA = 2'b00,
      SEG_STACK = 2'b01,
      SEG_CODE  = 2'b10,
      SEG_DATA  = 2'b11
   } seg_e;

   // Clock states of one bus cycle
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,   // address out, latch enable
      ST_STAT,   // status out, strobe asserted
      ST_DATA,   // data state, ready sampled at its end
      ST_WAIT,   // inserted while ready is low
      ST_REL     // strobe released
   } bst_e;
endpackage

// File: rtl/mxbus_plan.sv
module mxbus_plan #(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              is_word,
   input  logic              phase,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic              bhe_n,
   output logic              split
);
   // odd-address word takes two byte cycles
   assign split    = is_word & base_addr[0];
   assign cyc_addr = (split & phase) ? base_addr + ADDR_W'(1) : base_addr;

   always_comb begin
      if (is_word && !split) bhe_n = 1'b0;
      else                   bhe_n = ~cyc_addr[0];
   end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
   import mxbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ready,
   input  logic split,
   output bst_e state,
   output logic phase,
   output logic sample,
   output logic last
);
   logic more;
   assign more   = split & ~phase;
   assign sample = ((state == ST_DATA) || (state == ST_WAIT)) && ready;
   assign last   = (state == ST_REL) && !more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         phase <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_ADDR;
               phase <= 1'b0;
            end
            ST_ADDR: state <= ST_STAT;
            ST_STAT: state <= ST_DATA;
            ST_DATA: state <= ready ? ST_REL : ST_WAIT;
            ST_WAIT: state <= ready ? ST_REL : ST_WAIT;
            ST_REL: begin
               if (more) begin
                  state <= ST_ADDR;
                  phase <= 1'b1;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mxbus_lane.sv
module mxbus_lane #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              is_word,
   input  logic              split,
   input  logic              phase,
   input  logic              cyc_a0,
   input  logic              sample,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] lane_out,
   output logic [DATA_W-1:0] rd_data
);
   localparam int BYTE_W = 8;
   localparam int NLANE  = DATA_W / BYTE_W;

   logic              full_word;
   logic [BYTE_W-1:0] cur_byte;
   logic [BYTE_W-1:0] in_byte;

   assign full_word = is_word & ~split;
   assign cur_byte  = (split & phase) ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
   assign in_byte   = cyc_a0 ? ad_in[2*BYTE_W-1:BYTE_W] : ad_in[BYTE_W-1:0];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_out[g*BYTE_W +: BYTE_W] = full_word ? wdata[g*BYTE_W +: BYTE_W] : cur_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (sample) begin
         if (full_word)          rd_data <= ad_in;
         else if (split & phase) rd_data[2*BYTE_W-1:BYTE_W] <= in_byte;
         else                    rd_data <= {{(DATA_W-BYTE_W){1'b0}}, in_byte};
      end
   end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
   import mxbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [1:0]               req_seg,
   input  logic                     req_mem,
   input  logic                     req_write,
   input  logic                     req_word,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     req_ie,
   output logic                     busy,
   output logic                     done,
   output logic [DATA_W-1:0]        rd_data,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   input  logic [DATA_W-1:0]        bus_ad_in,
   output logic [ADDR_W-DATA_W-1:0] bus_ahs,
   output logic                     bus_bhe_n,
   output logic                     bus_ale,
   output logic                     bus_mio,
   output logic                     bus_dtr,
   output logic                     bus_rd_n,
   output logic                     bus_wr_n,
   input  logic                     bus_ready
);
   localparam int STAT_W = ADDR_W - DATA_W;
   localparam int BYTE_W = 8;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_data
      $error("mxbus_ctrl: DATA_W must be two byte lanes");
   end
   if (STAT_W != 4) begin : g_bad_stat
      $error("mxbus_ctrl: ADDR_W - DATA_W must be 4 status lines");
   end

   bst_e              st;
   logic              phase, sample, last, split, start;
   logic [ADDR_W-1:0] cyc_addr;
   logic              plan_bhe_n;
   logic [DATA_W-1:0] lane_out;

   logic [ADDR_W-1:0] r_addr;
   logic [1:0]        r_seg;
   logic              r_mem, r_write, r_word, r_ie;
   logic [DATA_W-1:0] r_wdata;

   assign start = req_valid && (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_addr  <= '0;
         r_seg   <= '0;
         r_mem   <= 1'b0;
         r_write <= 1'b0;
         r_word  <= 1'b0;
         r_ie    <= 1'b0;
         r_wdata <= '0;
      end else if (start) begin
         r_addr  <= req_addr;
         r_seg   <= req_seg;
         r_mem   <= req_mem;
         r_write <= req_write;
         r_word  <= req_word;
         r_ie    <= req_ie;
         r_wdata <= req_wdata;
      end
   end

   mxbus_plan #(.ADDR_W(ADDR_W)) u_plan (
      .base_addr (r_addr),
      .is_word   (r_word),
      .phase     (phase),
      .cyc_addr  (cyc_addr),
      .bhe_n     (plan_bhe_n),
      .split     (split)
   );

   mxbus_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .ready  (bus_ready),
      .split  (split),
      .state  (st),
      .phase  (phase),
      .sample (sample),
      .last   (last)
   );

   mxbus_lane #(.DATA_W(DATA_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdata    (r_wdata),
      .is_word  (r_word),
      .split    (split),
      .phase    (phase),
      .cyc_a0   (cyc_addr[0]),
      .sample   (sample & ~r_write),
      .ad_in    (bus_ad_in),
      .lane_out (lane_out),
      .rd_data  (rd_data)
   );

   logic active, strobe, addr_st;
   assign active  = (st != ST_IDLE);
   assign addr_st = (st == ST_ADDR);
   assign strobe  = (st == ST_STAT) || (st == ST_DATA) || (st == ST_WAIT);

   assign busy       = active;
   assign done       = last;
   assign bus_ale    = addr_st;
   assign bus_ad_oe  = addr_st || (active && r_write);
   assign bus_ad_out = addr_st ? cyc_addr[DATA_W-1:0]
                     : (active && r_write) ? lane_out : '0;
   assign bus_ahs    = addr_st ? cyc_addr[ADDR_W-1:DATA_W]
                     : active  ? STAT_W'({1'b0, r_ie, r_seg}) : '0;
   assign bus_bhe_n  = active ? plan_bhe_n : 1'b1;
   assign bus_mio    = active ? r_mem : 1'b1;
   assign bus_dtr    = active ? r_write : 1'b1;
   assign bus_rd_n   = ~(strobe & ~r_write);
   assign bus_wr_n   = ~(strobe & r_write);
endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk #(
   parameter int STAT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              bus_ad_oe,
   input logic [STAT_W-1:0] bus_ahs,
   input logic              bus_bhe_n,
   input logic              bus_ale,
   input logic              bus_mio,
   input logic              bus_dtr,
   input logic              bus_rd_n,
   input logic              bus_wr_n,
   input logic              bus_ready
);
   logic strb;
   assign strb = !bus_rd_n || !bus_wr_n;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe));
   // R2
   ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> !bus_ale);
   // R3
   s6_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (bus_ahs[STAT_W-1] == 1'b0));
   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));
   // R4
   ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> strb);
   // R5
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !bus_ready) |=> strb);
   // R6
   attr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> ($stable(bus_mio) && $stable(bus_dtr) && $stable(bus_bhe_n)));
   // R8
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_ad_oe);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_rd_n && bus_wr_n));
endmodule

bind mxbus_ctrl mxbus_ctrl_chk u_chk (.*);

// File: tb/mxbus_ctrl_bench.sv
module mxbus_ctrl_bench;
   import mxbus_pkg::*;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic [1:0]  req_seg = '0;
   logic        req_mem = 1'b0, req_write = 1'b0, req_word = 1'b0, req_ie = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        busy, done;
   logic [15:0] rd_data, bus_ad_out;
   logic        bus_ad_oe;
   logic [15:0] bus_ad_in = '0;
   logic [3:0]  bus_ahs;
   logic        bus_bhe_n, bus_ale, bus_mio, bus_dtr, bus_rd_n, bus_wr_n;
   logic        bus_ready = 1'b1;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mxbus_ctrl u_mxbus_ctrl (.*);

   typedef struct {
      logic [19:0] addr;
      logic        bhe_n;
      logic [3:0]  stat;
      logic        mio;
      logic        wr;
      logic [15:0] wbus;
      int          waits;
   } exp_t;
   exp_t exp_q[$];

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h9};
   endfunction

   function automatic logic [15:0] resp(input logic [19:0] c);
      return {mb(c | 20'h1), mb(c & 20'hFFFFE)};
   endfunction

   // Bus-side monitor and responder: pops one expected cycle per latch pulse
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && bus_ale) begin
            exp_t it;
            int   k;
            if (exp_q.size() == 0) begin
               chk(0, "R11 unexpected bus cycle", {12'h0, bus_ahs, bus_ad_out}, 32'h0);
            end else begin
               it = exp_q.pop_front();
               // T1
               chk({bus_ahs, bus_ad_out} == it.addr, "R2 address", {bus_ahs, bus_ad_out}, it.addr);
               chk(bus_ad_oe == 1'b1, "R2 drive in address state", bus_ad_oe, 1);
               chk(bus_bhe_n == it.bhe_n, "R7 bhe_n", bus_bhe_n, it.bhe_n);
               chk(bus_mio == it.mio && bus_dtr == it.wr, "R6 mio/dtr",
                   {bus_mio, bus_dtr}, {it.mio, it.wr});
               // T2
               @(negedge clk);
               chk(bus_ahs == it.stat, "R3 status", bus_ahs, it.stat);
               chk(bus_rd_n == it.wr && bus_wr_n == !it.wr && !bus_ale, "R4 strobe assert",
                   {bus_ale, bus_rd_n, bus_wr_n}, {1'b0, it.wr, !it.wr});
               chk(bus_ad_oe == it.wr, "R8 drive enable", bus_ad_oe, it.wr);
               if (it.wr) chk(bus_ad_out == it.wbus, "R8 write lanes", bus_ad_out, it.wbus);
               // data and wait states
               k = 0;
               while (1) begin
                  @(negedge clk);
                  chk(bus_rd_n == it.wr && bus_wr_n == !it.wr, "R5 strobe held",
                      {bus_rd_n, bus_wr_n}, {it.wr, !it.wr});
                  chk(bus_mio == it.mio && bus_dtr == it.wr && bus_bhe_n == it.bhe_n,
                      "R6 attributes held", {bus_mio, bus_dtr, bus_bhe_n}, {it.mio, it.wr, it.bhe_n});
                  bus_ready = (k == it.waits);
                  bus_ad_in = resp(it.addr);
                  if (k == it.waits) break;
                  bus_ad_in = ~resp(it.addr); // wrong value until the final data state
                  k++;
               end
               // T4
               @(negedge clk);
               bus_ready = 1'b1;
               bus_ad_in = 16'hDEAD;
               chk(bus_rd_n && bus_wr_n, "R4 strobe release", {bus_rd_n, bus_wr_n}, 2'b11);
               if (it.wr) chk(bus_ad_oe && bus_ad_out == it.wbus, "R8 data held to release",
                              {bus_ad_oe, bus_ad_out}, {1'b1, it.wbus});
            end
         end
      end
   end

   task automatic run_req(input logic [19:0] a, input seg_e sg, input logic mem,
                          input logic wr, input logic wd, input logic ie,
                          input logic [15:0] w, input int waits, input bit hold,
                          input string rq);
      exp_t        it;
      logic [19:0] a1;
      logic [15:0] erd;
      int          n, ncyc;
      bit          sp;
      a1 = a + 20'd1;
      sp = wd && a[0];
      it.stat = {1'b0, ie, sg};
      it.mio = mem; it.wr = wr; it.waits = waits;
      if (sp) begin
         it.addr = a;  it.bhe_n = 1'b0; it.wbus = {w[7:0], w[7:0]};
         exp_q.push_back(it);
         it.addr = a1; it.bhe_n = 1'b1; it.wbus = {w[15:8], w[15:8]};
         exp_q.push_back(it);
         erd  = {mb(a1), mb(a)};
         ncyc = 8 + 2 * waits;
      end else begin
         it.addr  = a;
         it.bhe_n = wd ? 1'b0 : ~a[0];
         it.wbus  = wd ? w : {w[7:0], w[7:0]};
         exp_q.push_back(it);
         erd  = wd ? {mb(a1), mb(a)} : {8'h00, mb(a)};
         ncyc = 4 + waits;
      end
      @(negedge clk);
      req_addr = a; req_seg = sg; req_mem = mem; req_write = wr;
      req_word = wd; req_ie = ie; req_wdata = w; req_valid = 1'b1;
      @(negedge clk);
      n = 1;
      if (!hold) req_valid = 1'b0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      chk(n == ncyc, "R11 done latency", n, ncyc);
      if (!wr) chk(rd_data == erd, rq, rd_data, erd);
      @(negedge clk);
      chk(!done && !busy, "R11 done one pulse, idle after", {done, busy}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe, "R1 reset state",
          {busy, done, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe}, 6'b000110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && bus_rd_n && bus_wr_n && !bus_ale, "R1 idle after reset",
          {busy, bus_rd_n, bus_wr_n, bus_ale}, 4'b0110);
      run_req(20'h2A050, SEG_CODE,  1, 1, 1, 1, 16'hBEEF, 0, 0, "R8");
      run_req(20'h4C3E2, SEG_DATA,  1, 0, 1, 0, 16'h0,    2, 0, "R9 word read");
      run_req(20'h00137, SEG_STACK, 0, 0, 0, 0, 16'h0,    0, 0, "R9 odd byte read");
      run_req(20'h81234, SEG_EXTRA, 1, 1, 0, 1, 16'h77A5, 1, 0, "R8");
      run_req(20'h81235, SEG_DATA,  0, 1, 0, 0, 16'h1C3D, 0, 0, "R8");
      run_req(20'h5F0A6, SEG_STACK, 1, 0, 0, 1, 16'h0,    3, 0, "R9 even byte read");
      run_req(20'h30071, SEG_CODE,  1, 1, 1, 0, 16'hA1B2, 1, 0, "R10 split write");
      run_req(20'hFFFFF, SEG_DATA,  1, 0, 1, 1, 16'h0,    0, 0, "R10 split read wrap");
      run_req(20'h12345, SEG_EXTRA, 1, 0, 1, 0, 16'h0,    2, 0, "R10 split read waits");
      run_req(20'h06660, SEG_CODE,  1, 0, 1, 1, 16'h0,    1, 1, "R11 held request read");
      run_req(20'h06662, SEG_DATA,  0, 1, 1, 0, 16'h5A5A, 0, 0, "R8");
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && !busy, "R11 no leftover cycles", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule